// File: doc/BRIEF.md
# Processor Control Register Access Unit

This block holds the bank of processor control registers that a move-to or move-from control register instruction reaches. The instruction decoder presents a 12-bit selector, a direction bit and, on writes, a 32-bit value. The unit decides whether that selector exists on the processor generation chosen at compile time. It masks a written value down to the bits that generation implements, and returns the masked contents on reads. An access the generation does not support raises a one-cycle illegal-instruction flag and changes nothing.

Two of the registers, the master stack pointer and the interrupt stack pointer, share the live address register 7 with the register file. The stack mode bit M picks which one is live. A write to the live one is forwarded to the register file, and a read of it returns the register file's current value. Cache, translation and instruction-cache effects belong to other blocks. This unit only signals them with single-cycle pulses.

Top module: `ctrlreg_unit`

## Requirements
- R1: After a synchronous active-high reset, every control register reads zero, M is 0, and every output is 0.
- R2: Legality by `CPU_GEN`. Generation 1 accepts a selector whose low 11 bits are below 2. Generation 2 accepts a selector whose low 11 bits are below 4, or 0x804, but never 0x003. Generation 3 accepts low 11 bits up to 2, plus 0x803 and 0x804. Generation 4 accepts low 11 bits below 8, except 0x802. Generation 6 accepts 0x000 to 0x008 and 0x800, 0x801, 0x806, 0x807 and 0x808. The only selectors that name registers are 0x000 to 0x008 and 0x800 to 0x808, and all others are illegal.
- R3: An illegal access sets `acc_illegal` for exactly one cycle. It changes no register, raises no pulse output and no `a7_we`, and an illegal read returns zero on `rd_data`.
- R4: Fixed write masks. Source and destination function code (0x000, 0x001) keep bits 2:0. The four transparent-translation registers (0x004 to 0x007) keep 0xFFFFE364. Bus control (0x008) keeps 0xF0000000. The user and supervisor root pointers (0x806, 0x807) keep 0xFFFFFE00. User stack (0x800), vector base (0x801), cache address (0x802) and MMU status (0x805) keep all 32 bits.
- R5: Cache control (0x002) is masked on write with 0x0000000F, 0x00003F1F, 0x80008000 or 0xF8E0E000 for generation 2, 3, 4 or 6. It is masked on read with 0x00000003, 0x00003313, 0x80008000 or 0xF880E000.
- R6: Translation control (0x003) keeps 0xFFFE on generation 6 and 0xC000 on other generations.
- R7: When M is 1, the master stack pointer (0x803) is live. When M is 0, the interrupt stack pointer (0x804) is live. A legal write to the live one pulses `a7_we` with `a7_wdata` equal to the written value. A read of the live one returns `a7_live`. The other pointer reads its stored copy. `m_load` loads M from `m_value`, and the new M applies to accesses from the next cycle on.
- R8: A write to processor configuration (0x808) replaces only bits 6, 1 and 0. With `HAS_FPU` = 0, bit 1 is forced to 1. If the stored bit 1 changes, `icache_flush` pulses.
- R9: `cacr_upd`, `tc_upd` and `tt_upd` each pulse for one cycle after a legal write to 0x002, 0x003 or 0x004 to 0x007 respectively, and never otherwise.
- R10: Every output is registered and reflects the access presented in the previous cycle. `rd_data` changes only on a read access and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write to control register, 0 = read |
| acc_sel | input | 12 | Control register selector |
| acc_wdata | input | 32 | Value to write |
| m_load | input | 1 | Load the stack mode bit |
| m_value | input | 1 | New stack mode bit value |
| a7_live | input | 32 | Current address register 7 from the register file |
| rd_data | output | 32 | Read result |
| acc_illegal | output | 1 | Illegal-instruction pulse |
| a7_we | output | 1 | Write address register 7 in the register file |
| a7_wdata | output | 32 | Value for address register 7 |
| cacr_upd | output | 1 | Cache control was written |
| tc_upd | output | 1 | Translation control was written |
| tt_upd | output | 1 | A transparent-translation register was written |
| icache_flush | output | 1 | Instruction cache flush request |

## Verification
Every result appears one clock edge after the cycle in which the access is presented. This covers read data, the illegal flag, the side-effect pulses and the stack pointer forward. The bench therefore drives an access on a falling edge, lets one rising edge pass, removes the request, and samples on the next falling edge, where the pulses are still high. A separate check samples `rd_data` before that rising edge, to show the old value is still there, and samples the illegal flag one cycle later, to show it has already fallen. An M change is loaded one cycle ahead of the access that depends on it.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

   localparam int NREG  = 18;
   localparam int IDX_W = 5;

   // bank indices; selectors 0x000..0x008 map to 0..8, 0x800..0x808 to 9..17
   localparam logic [IDX_W-1:0] IX_SRC_FC     = 5'd0;
   localparam logic [IDX_W-1:0] IX_DST_FC     = 5'd1;
   localparam logic [IDX_W-1:0] IX_CACHE_CTL  = 5'd2;
   localparam logic [IDX_W-1:0] IX_XLAT_CTL   = 5'd3;
   localparam logic [IDX_W-1:0] IX_ITRANS0    = 5'd4;
   localparam logic [IDX_W-1:0] IX_DTRANS1    = 5'd7;
   localparam logic [IDX_W-1:0] IX_BUS_CTL    = 5'd8;
   localparam logic [IDX_W-1:0] IX_MASTER_SP  = 5'd12;
   localparam logic [IDX_W-1:0] IX_INT_SP     = 5'd13;
   localparam logic [IDX_W-1:0] IX_USER_ROOT  = 5'd15;
   localparam logic [IDX_W-1:0] IX_SUP_ROOT   = 5'd16;
   localparam logic [IDX_W-1:0] IX_PROC_CFG   = 5'd17;

   localparam logic [31:0] CFG_WBITS   = 32'h0000_0043;
   localparam logic [31:0] CFG_NOFPU   = 32'h0000_0002;
   localparam logic [31:0] TRANS_MASK  = 32'hFFFF_E364;
   localparam logic [31:0] ROOT_MASK   = 32'hFFFF_FE00;
   localparam logic [31:0] BUS_MASK    = 32'hF000_0000;

   function automatic logic [31:0] cache_wmask(int gen);
      case (gen)
         2:       return 32'h0000_000F;
         3:       return 32'h0000_3F1F;
         4:       return 32'h8000_8000;
         6:       return 32'hF8E0_E000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] cache_rmask(int gen);
      case (gen)
         2:       return 32'h0000_0003;
         3:       return 32'h0000_3313;
         4:       return 32'h8000_8000;
         6:       return 32'hF880_E000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] reg_wmask(int gen, logic [IDX_W-1:0] ix);
      if (ix == IX_SRC_FC || ix == IX_DST_FC) return 32'h7;
      if (ix == IX_CACHE_CTL)                 return cache_wmask(gen);
      if (ix == IX_XLAT_CTL)                  return (gen == 6) ? 32'hFFFE : 32'hC000;
      if (ix >= IX_ITRANS0 && ix <= IX_DTRANS1) return TRANS_MASK;
      if (ix == IX_BUS_CTL)                   return BUS_MASK;
      if (ix == IX_USER_ROOT || ix == IX_SUP_ROOT) return ROOT_MASK;
      return 32'hFFFF_FFFF;
   endfunction

endpackage

// File: rtl/ctrlreg_legal.sv
module ctrlreg_legal
   import ctrlreg_pkg::*;
#(
   parameter int CPU_GEN = 6,
   parameter int SEL_W   = 12
) (
   input  logic [SEL_W-1:0] sel,
   output logic             legal,
   output logic [IDX_W-1:0] idx
);
   localparam int LO_W = SEL_W - 1;

   logic [LO_W-1:0] lo;
   logic            hi;
   logic            mapped;
   logic            gen_ok;

   assign lo     = sel[LO_W-1:0];
   assign hi     = sel[SEL_W-1];
   assign mapped = (lo[LO_W-1:4] == '0) && (lo[3:0] <= 4'd8);
   assign idx    = hi ? (IDX_W'(9) + {1'b0, lo[3:0]}) : {1'b0, lo[3:0]};

   generate
      if (CPU_GEN == 1) begin : g_gen1
         assign gen_ok = lo < LO_W'(2);
      end else if (CPU_GEN == 2) begin : g_gen2
         assign gen_ok = (sel != SEL_W'('h003)) &&
                         ((lo < LO_W'(4)) || (sel == SEL_W'('h804)));
      end else if (CPU_GEN == 3) begin : g_gen3
         assign gen_ok = (lo <= LO_W'(2)) ||
                         (sel == SEL_W'('h803)) || (sel == SEL_W'('h804));
      end else if (CPU_GEN == 4) begin : g_gen4
         assign gen_ok = (sel != SEL_W'('h802)) && (lo < LO_W'(8));
      end else begin : g_gen6
         assign gen_ok = (sel <= SEL_W'('h008)) ||
                         (sel == SEL_W'('h800)) || (sel == SEL_W'('h801)) ||
                         (sel == SEL_W'('h806)) || (sel == SEL_W'('h807)) ||
                         (sel == SEL_W'('h808));
      end
   endgenerate

   assign legal = mapped && gen_ok;

endmodule

// File: rtl/ctrlreg_bank.sv
module ctrlreg_bank
   import ctrlreg_pkg::*;
#(
   parameter int CPU_GEN = 6,
   parameter bit HAS_FPU = 1'b1,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              m_bit,
   input  logic [DATA_W-1:0] a7_live,
   output logic [DATA_W-1:0] rd_val,
   output logic              a7_we_c,
   output logic              flush_c
);
   localparam logic [DATA_W-1:0] FPU_FORCE = HAS_FPU ? '0 : DATA_W'(CFG_NOFPU);

   logic [DATA_W-1:0] q [NREG];
   logic [DATA_W-1:0] cfg_next;
   logic              in_range;

   assign in_range = idx < IDX_W'(NREG);
   assign cfg_next = (q[IX_PROC_CFG] & ~DATA_W'(CFG_WBITS)) |
                     (wdata & DATA_W'(CFG_WBITS)) | FPU_FORCE;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NREG; k++) q[k] <= '0;
      end else if (wr_en && in_range) begin
         if (idx == IX_PROC_CFG) q[idx] <= cfg_next;
         else                    q[idx] <= wdata & DATA_W'(reg_wmask(CPU_GEN, idx));
      end
   end

   assign flush_c = wr_en && (idx == IX_PROC_CFG) &&
                    (cfg_next[1] != q[IX_PROC_CFG][1]);
   assign a7_we_c = wr_en && (((idx == IX_MASTER_SP) && m_bit) ||
                              ((idx == IX_INT_SP) && !m_bit));

   always_comb begin
      rd_val = '0;
      if (in_range) begin
         rd_val = q[idx];
         if (idx == IX_CACHE_CTL)
            rd_val = q[idx] & DATA_W'(cache_rmask(CPU_GEN));
         if ((idx == IX_MASTER_SP && m_bit) || (idx == IX_INT_SP && !m_bit))
            rd_val = a7_live;
      end
   end

endmodule

// File: rtl/ctrlreg_unit.sv
module ctrlreg_unit
   import ctrlreg_pkg::*;
#(
   parameter int CPU_GEN = 6,
   parameter bit HAS_FPU = 1'b1,
   parameter int SEL_W   = 12,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [SEL_W-1:0]  acc_sel,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              m_load,
   input  logic              m_value,
   input  logic [DATA_W-1:0] a7_live,
   output logic [DATA_W-1:0] rd_data,
   output logic              acc_illegal,
   output logic              a7_we,
   output logic [DATA_W-1:0] a7_wdata,
   output logic              cacr_upd,
   output logic              tc_upd,
   output logic              tt_upd,
   output logic              icache_flush
);
   generate
      if (!(CPU_GEN == 1 || CPU_GEN == 2 || CPU_GEN == 3 || CPU_GEN == 4 || CPU_GEN == 6))
      begin : g_bad_gen
         $error("ctrlreg_unit: CPU_GEN must be 1, 2, 3, 4 or 6");
      end
      if (SEL_W != 12) begin : g_bad_sel
         $error("ctrlreg_unit: SEL_W must be 12");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("ctrlreg_unit: DATA_W must be 32");
      end
   endgenerate

   logic              legal;
   logic [IDX_W-1:0]  idx;
   logic              wr_en;
   logic [DATA_W-1:0] rd_val;
   logic              a7_we_c;
   logic              flush_c;
   logic              m_q;

   ctrlreg_legal #(.CPU_GEN(CPU_GEN), .SEL_W(SEL_W)) u_legal (
      .sel   (acc_sel),
      .legal (legal),
      .idx   (idx)
   );

   assign wr_en = acc_en && acc_wr && legal;

   ctrlreg_bank #(.CPU_GEN(CPU_GEN), .HAS_FPU(HAS_FPU), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .idx     (idx),
      .wdata   (acc_wdata),
      .m_bit   (m_q),
      .a7_live (a7_live),
      .rd_val  (rd_val),
      .a7_we_c (a7_we_c),
      .flush_c (flush_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         m_q          <= 1'b0;
         rd_data      <= '0;
         acc_illegal  <= 1'b0;
         a7_we        <= 1'b0;
         a7_wdata     <= '0;
         cacr_upd     <= 1'b0;
         tc_upd       <= 1'b0;
         tt_upd       <= 1'b0;
         icache_flush <= 1'b0;
      end else begin
         if (m_load) m_q <= m_value;
         if (acc_en && !acc_wr) rd_data <= legal ? rd_val : '0;
         acc_illegal  <= acc_en && !legal;
         a7_we        <= a7_we_c;
         if (a7_we_c) a7_wdata <= acc_wdata;
         cacr_upd     <= wr_en && (idx == IX_CACHE_CTL);
         tc_upd       <= wr_en && (idx == IX_XLAT_CTL);
         tt_upd       <= wr_en && (idx >= IX_ITRANS0) && (idx <= IX_DTRANS1);
         icache_flush <= flush_c;
      end
   end

endmodule

// File: rtl/ctrlreg_unit_chk.sv
module ctrlreg_unit_chk (
   input logic        clk,
   input logic        rst,
   input logic        acc_en,
   input logic        acc_wr,
   input logic [11:0] acc_sel,
   input logic [31:0] acc_wdata,
   input logic [31:0] rd_data,
   input logic        acc_illegal,
   input logic        a7_we,
   input logic [31:0] a7_wdata,
   input logic        cacr_upd,
   input logic        tc_upd,
   input logic        tt_upd,
   input logic        icache_flush
);
   p_illegal_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      acc_illegal |-> !(a7_we || cacr_upd || tc_upd || tt_upd || icache_flush));

   p_illegal_rd_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (acc_illegal && $past(!acc_wr)) |-> (rd_data == 32'h0));

   p_fc_width_r4: assert property (@(posedge clk) disable iff (rst)
      (acc_en && !acc_wr && acc_sel <= 12'h001) |=> (rd_data[31:3] == 29'h0));

   p_a7_fwd_r7: assert property (@(posedge clk) disable iff (rst)
      a7_we |-> ($past(acc_en && acc_wr) && a7_wdata == $past(acc_wdata)));

   p_cacr_src_r9: assert property (@(posedge clk) disable iff (rst)
      cacr_upd |-> $past(acc_en && acc_wr && acc_sel == 12'h002));

   p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot0({cacr_upd, tc_upd, tt_upd, icache_flush, a7_we}));

   p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
      $past(!(acc_en && !acc_wr)) |-> $stable(rd_data));

endmodule

bind ctrlreg_unit ctrlreg_unit_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .acc_en       (acc_en),
   .acc_wr       (acc_wr),
   .acc_sel      (acc_sel),
   .acc_wdata    (acc_wdata),
   .rd_data      (rd_data),
   .acc_illegal  (acc_illegal),
   .a7_we        (a7_we),
   .a7_wdata     (a7_wdata),
   .cacr_upd     (cacr_upd),
   .tc_upd       (tc_upd),
   .tt_upd       (tt_upd),
   .icache_flush (icache_flush)
);

// File: tb/ctrlreg_unit_tb.sv
module ctrlreg_unit_tb;
   localparam int NDUT = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        acc_en = 1'b0;
   logic        acc_wr = 1'b0;
   logic [11:0] acc_sel = '0;
   logic [31:0] acc_wdata = '0;
   logic        m_load = 1'b0;
   logic        m_value = 1'b0;
   logic [31:0] a7_live = '0;

   logic [31:0] rd   [NDUT];
   logic        ill  [NDUT];
   logic        a7we [NDUT];
   logic [31:0] a7wd [NDUT];
   logic        cu   [NDUT];
   logic        tu   [NDUT];
   logic        ttu  [NDUT];
   logic        fl   [NDUT];

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   function automatic int gen_of(int i);
      case (i)
         0: return 6;
         1: return 3;
         2: return 4;
         default: return 6;
      endcase
   endfunction

   function automatic bit fpu_of(int i);
      return i == 3;
   endfunction

   genvar gi;
   generate
      for (gi = 0; gi < NDUT; gi++) begin : g_dut
         ctrlreg_unit #(.CPU_GEN(gen_of(gi)), .HAS_FPU(fpu_of(gi))) u_dut (
            .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
            .acc_sel(acc_sel), .acc_wdata(acc_wdata), .m_load(m_load),
            .m_value(m_value), .a7_live(a7_live), .rd_data(rd[gi]),
            .acc_illegal(ill[gi]), .a7_we(a7we[gi]), .a7_wdata(a7wd[gi]),
            .cacr_upd(cu[gi]), .tc_upd(tu[gi]), .tt_upd(ttu[gi]),
            .icache_flush(fl[gi])
         );
      end
   endgenerate

   // expected legality (R2)
   function automatic bit exp_legal(int g, logic [11:0] s);
      logic [10:0] lo;
      lo = s[10:0];
      case (g)
         3: return (lo <= 2) || s == 12'h803 || s == 12'h804;
         4: return (s != 12'h802) && (lo < 8);
         default: return (s <= 12'h008) || s == 12'h800 || s == 12'h801 ||
                         s == 12'h806 || s == 12'h807 || s == 12'h808;
      endcase
   endfunction

   // expected write masks (R4, R5, R6)
   function automatic logic [31:0] exp_wm(int g, logic [11:0] s);
      if (s <= 12'h001) return 32'h7;
      if (s == 12'h002)
         return (g == 3) ? 32'h3F1F : (g == 4) ? 32'h80008000 : 32'hF8E0E000;
      if (s == 12'h003) return (g == 6) ? 32'hFFFE : 32'hC000;
      if (s >= 12'h004 && s <= 12'h007) return 32'hFFFFE364;
      if (s == 12'h008) return 32'hF0000000;
      if (s == 12'h806 || s == 12'h807) return 32'hFFFFFE00;
      return 32'hFFFFFFFF;
   endfunction

   function automatic logic [31:0] exp_rm(int g, logic [11:0] s);
      if (s == 12'h002)
         return (g == 3) ? 32'h3313 : (g == 4) ? 32'h80008000 : 32'hF880E000;
      return 32'hFFFFFFFF;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive one access on a falling edge; outputs valid at the returning falling edge
   task automatic acc(input logic wr, input logic [11:0] s, input logic [31:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; acc_sel = s; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic set_m(input logic v);
      @(negedge clk);
      m_load = 1'b1; m_value = v;
      @(negedge clk);
      m_load = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [11:0] s;
      logic [31:0] pat;
      bit lg;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      for (int i = 0; i < NDUT; i++) begin
         check("R1", "rd_data", rd[i], 32'h0);
         check("R1", "flags", {ill[i], a7we[i], cu[i], tu[i], ttu[i], fl[i]}, 32'h0);
      end

      // R2/R3/R1: sweep all selectors as reads; everything reads zero after reset
      for (int k = 0; k < 4096; k++) begin
         acc(1'b0, 12'(k), 32'h0);
         for (int i = 0; i < NDUT; i++) begin
            lg = exp_legal(gen_of(i), 12'(k));
            check("R2", "illegal flag", {31'h0, ill[i]}, {31'h0, !lg});
            check("R1", "reset readback", rd[i], 32'h0);
         end
      end

      // R4/R5/R6/R9: masked write and readback of plain registers
      a7_live = 32'h1111_1111;
      for (int p = 0; p < 2; p++) begin
         pat = (p == 0) ? 32'hFFFF_FFFF : 32'hA5A5_5A5A;
         for (int k = 0; k < 18; k++) begin
            s = (k < 9) ? 12'(k) : 12'(12'h800 + k - 9);
            if (s == 12'h803 || s == 12'h804 || s == 12'h808) continue;
            acc(1'b1, s, pat);
            for (int i = 0; i < NDUT; i++) begin
               lg = exp_legal(gen_of(i), s);
               check("R9", "cacr_upd", {31'h0, cu[i]}, {31'h0, lg && s == 12'h002});
               check("R9", "tc_upd", {31'h0, tu[i]}, {31'h0, lg && s == 12'h003});
               check("R9", "tt_upd", {31'h0, ttu[i]},
                     {31'h0, lg && s >= 12'h004 && s <= 12'h007});
            end
            acc(1'b0, s, 32'h0);
            for (int i = 0; i < NDUT; i++) begin
               lg = exp_legal(gen_of(i), s);
               check((s == 12'h002) ? "R5" : (s == 12'h003) ? "R6" : "R4", "readback",
                     rd[i], lg ? (pat & exp_wm(gen_of(i), s) & exp_rm(gen_of(i), s)) : 32'h0);
            end
         end
      end

      // R3: illegal writes change nothing and raise no side effects
      acc(1'b1, 12'h801, 32'hCAFE_0000);
      acc(1'b1, 12'h809, 32'hFFFF_FFFF);
      for (int i = 0; i < NDUT; i++) begin
         check("R3", "illegal flag 0x809", {31'h0, ill[i]}, 32'h1);
         check("R3", "no side pulse", {26'h0, a7we[i], cu[i], tu[i], ttu[i], fl[i], 1'b0}, 32'h0);
      end
      acc(1'b1, 12'h100, 32'hFFFF_FFFF);
      acc(1'b1, 12'h80F, 32'hFFFF_FFFF);
      acc(1'b0, 12'h801, 32'h0);
      for (int i = 0; i < NDUT; i++) check("R3", "vector base kept", rd[i], 32'hCAFE_0000);
      acc(1'b0, 12'h100, 32'h0);
      for (int i = 0; i < NDUT; i++) check("R3", "illegal read zero", rd[i], 32'h0);

      // R7: stack pointer aliasing (generations 3 and 4 carry both pointers)
      acc(1'b1, 12'h804, 32'h0000_1000);
      for (int i = 0; i < NDUT; i++) begin
         check("R7", "a7_we isp M0", {31'h0, a7we[i]}, {31'h0, i == 1 || i == 2});
         if (i == 1 || i == 2) check("R7", "a7_wdata", a7wd[i], 32'h0000_1000);
      end
      a7_live = 32'h2222_0000;
      acc(1'b0, 12'h804, 32'h0);
      for (int i = 1; i < 3; i++) check("R7", "isp live M0", rd[i], 32'h2222_0000);
      acc(1'b1, 12'h803, 32'h0000_3000);
      for (int i = 0; i < NDUT; i++) check("R7", "a7_we msp M0", {31'h0, a7we[i]}, 32'h0);
      acc(1'b0, 12'h803, 32'h0);
      for (int i = 1; i < 3; i++) check("R7", "msp stored M0", rd[i], 32'h0000_3000);
      set_m(1'b1);
      acc(1'b0, 12'h803, 32'h0);
      for (int i = 1; i < 3; i++) check("R7", "msp live M1", rd[i], 32'h2222_0000);
      acc(1'b0, 12'h804, 32'h0);
      for (int i = 1; i < 3; i++) check("R7", "isp stored M1", rd[i], 32'h0000_1000);
      acc(1'b1, 12'h803, 32'h0000_4000);
      for (int i = 1; i < 3; i++) begin
         check("R7", "a7_we msp M1", {31'h0, a7we[i]}, 32'h1);
         check("R7", "a7_wdata M1", a7wd[i], 32'h0000_4000);
      end
      acc(1'b1, 12'h804, 32'h0000_5000);
      for (int i = 1; i < 3; i++) check("R7", "a7_we isp M1", {31'h0, a7we[i]}, 32'h0);
      acc(1'b0, 12'h804, 32'h0);
      for (int i = 1; i < 3; i++) check("R7", "isp stored write M1", rd[i], 32'h0000_5000);
      set_m(1'b0);

      // R8: processor configuration (index 0 without FPU, index 3 with FPU)
      acc(1'b1, 12'h808, 32'hFFFF_FFFF);
      check("R8", "flush nofpu set", {31'h0, fl[0]}, 32'h1);
      check("R8", "flush fpu set", {31'h0, fl[3]}, 32'h1);
      acc(1'b0, 12'h808, 32'h0);
      check("R8", "cfg nofpu ones", rd[0], 32'h43);
      check("R8", "cfg fpu ones", rd[3], 32'h43);
      acc(1'b1, 12'h808, 32'h0);
      check("R8", "flush nofpu clear", {31'h0, fl[0]}, 32'h0);
      check("R8", "flush fpu clear", {31'h0, fl[3]}, 32'h1);
      acc(1'b0, 12'h808, 32'h0);
      check("R8", "cfg nofpu zero", rd[0], 32'h02);
      check("R8", "cfg fpu zero", rd[3], 32'h00);
      acc(1'b1, 12'h808, 32'h0000_0040);
      check("R8", "flush nofpu b6", {31'h0, fl[0]}, 32'h0);
      check("R8", "flush fpu b6", {31'h0, fl[3]}, 32'h0);
      acc(1'b0, 12'h808, 32'h0);
      check("R8", "cfg nofpu b6", rd[0], 32'h42);
      check("R8", "cfg fpu b6", rd[3], 32'h40);

      // R10: registered timing and hold
      acc(1'b1, 12'h800, 32'h0);
      acc(1'b0, 12'h800, 32'h0);
      acc(1'b1, 12'h801, 32'h1234_5678);
      for (int i = 0; i < NDUT; i++) check("R10", "hold across write", rd[i], 32'h0);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b0; acc_sel = 12'h801;
      #1;
      for (int i = 0; i < NDUT; i++) check("R10", "before edge", rd[i], 32'h0);
      @(negedge clk);
      acc_en = 1'b0;
      for (int i = 0; i < NDUT; i++) check("R10", "after edge", rd[i], 32'h1234_5678);
      acc(1'b0, 12'h100, 32'h0);
      for (int i = 0; i < NDUT; i++) check("R10", "illegal raised", {31'h0, ill[i]}, 32'h1);
      @(negedge clk);
      for (int i = 0; i < NDUT; i++) check("R10", "illegal one cycle", {31'h0, ill[i]}, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule